// File: doc/BRIEF.md
# Flit Retry Replay Controller

This block makes flit delivery reliable between two dies. On the transmit side, every data flit from upstream gets an 8-bit sequence number. A copy of the flit stays in a circular replay buffer until the far end acknowledges it. Acknowledgements are cumulative: an acknowledge carrying sequence N releases every stored flit up to and including N. A negative acknowledge carrying N releases the same flits. The block then retransmits every flit still held, oldest first, and holds new upstream traffic until that retransmission finishes.

On the receive side, the block delivers a data flit only when its CRC checker reports no error and its sequence number is the next one expected. It answers every delivered flit with an acknowledge. It answers the first bad or out-of-order flit with a negative acknowledge. After that it drops mismatching flits without further complaint until the expected flit arrives. Acknowledges and negative acknowledges travel in a 2-bit command field and an 8-bit acknowledged-sequence field of outgoing flits. When no data flit is waiting, the block sends a command-only flit. A raw mode bypasses all of this.

The transmit engine has two states. **ST_SEND** moves to **ST_REPLAY** when an in-window negative acknowledge leaves flits outstanding. **ST_REPLAY** returns to **ST_SEND** once every held flit has been resent or released. The receive engine also has two states. **RX_OK** moves to **RX_WAIT** on a bad flit and raises a negative acknowledge. **RX_WAIT** returns to **RX_OK** when the expected flit arrives intact.

Top module: `flit_retry_ctrl`

## Requirements
- R1: After reset, no flit is offered on either output (tx_valid and dn_valid low). With tx_ready high, up_ready is high.
- R2: Outside raw mode, new data flits leave with tx_hasdata=1 and the upstream data unchanged. Their tx_seq starts at 0 and increments by one per flit, modulo 256.
- R3: At most DEPTH flits are held unacknowledged. When DEPTH are held, up_ready is low.
- R4: A received command 01 (acknowledge) with sequence N releases every held flit up to and including N. An N outside the held window is ignored.
- R5: A received command 10 (negative acknowledge) with sequence N first releases flits as for an acknowledge. It then resends every remaining held flit in order, starting at N+1, with the original data. up_ready stays low until the resend ends. This also works across the 255-to-0 wrap.
- R6: A received command 00 or 11 has no effect on the held flits. A command on a flit flagged by the CRC checker also has no effect.
- R7: A received data flit with no CRC error and the expected sequence is presented on dn_valid/dn_data one cycle later. The next outgoing flit then carries command 01 with tx_ackseq equal to that flit's sequence.
- R8: In RX_OK, a data flit with a CRC error or an unexpected sequence is not delivered. The next outgoing flit carries command 10 with tx_ackseq equal to the last in-order sequence.
- R9: In RX_WAIT, mismatching flits are dropped and no new command is raised. The expected flit is delivered and acknowledged, and the receiver returns to RX_OK.
- R10: A pending command is sent on the next outgoing flit. If no data flit is ready, a command-only flit (tx_valid=1, tx_hasdata=0) carries it. The command is cleared when that flit is accepted.
- R11: With raw_mode high, upstream flits pass straight to tx with command 00 and up_ready equal to tx_ready. Received flits are delivered one cycle later whatever the CRC flag. The sequence state does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| raw_mode | input | 1 | Bypass retry entirely |
| up_valid | input | 1 | Upstream flit offered |
| up_ready | output | 1 | Upstream flit accepted |
| up_data | input | DATA_W | Upstream flit payload |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Link accepts outgoing flit |
| tx_hasdata | output | 1 | Outgoing flit carries payload |
| tx_data | output | DATA_W | Outgoing payload |
| tx_seq | output | 8 | Sequence of outgoing payload |
| tx_cmd | output | 2 | Outgoing command (00 none, 01 ack, 10 nak) |
| tx_ackseq | output | 8 | Sequence the command refers to |
| rx_valid | input | 1 | Incoming flit valid |
| rx_hasdata | input | 1 | Incoming flit carries payload |
| rx_data | input | DATA_W | Incoming payload |
| rx_seq | input | 8 | Sequence of incoming payload |
| rx_cmd | input | 2 | Incoming command |
| rx_ackseq | input | 8 | Sequence the incoming command refers to |
| rx_crc_err | input | 1 | CRC checker flags incoming flit |
| dn_valid | output | 1 | Delivered flit valid |
| dn_data | output | DATA_W | Delivered payload |

## Verification
The transmit path is tried with a steady stream, a stream that fills the buffer, and a negative acknowledge in mid-window. A stale acknowledge followed by a zero-length release tells window checks apart from blind pointer moves. A stream of several hundred flits with periodic acknowledges crosses the sequence wrap, and a negative acknowledge straddling 255 to 0 confirms modulo handling. On receive, a CRC-flagged flit and an out-of-order flit each raise a negative acknowledge in RX_OK. A second mismatch in RX_WAIT shows the silent drop. Reserved commands, CRC-flagged negative acknowledges and raw traffic show what must be ignored.

// File: rtl/flit_retry_pkg.sv
package flit_retry_pkg;
    localparam int SEQ_W = 8;

    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_ACK  = 2'b01,
        CMD_NAK  = 2'b10,
        CMD_RSVD = 2'b11
    } hdr_cmd_e;

    typedef enum logic {
        ST_SEND   = 1'b0,
        ST_REPLAY = 1'b1
    } tx_state_e;

    typedef enum logic {
        RX_OK   = 1'b0,
        RX_WAIT = 1'b1
    } rx_state_e;
endpackage

// File: rtl/flit_replay_store.sv
module flit_replay_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) slot[wr_idx] <= wr_data;
    end

    assign rd_data = slot[rd_idx];
endmodule

// File: rtl/flit_replay_tx.sv
module flit_replay_tx
    import flit_retry_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_mode,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_hasdata,
    output logic [DATA_W-1:0] tx_data,
    output logic [SEQ_W-1:0]  tx_seq,
    output logic [1:0]        tx_cmd,
    output logic [SEQ_W-1:0]  tx_ackseq,
    input  hdr_cmd_e          pend_cmd,
    input  logic [SEQ_W-1:0]  pend_seq,
    output logic              cmd_taken,
    input  logic              fb_valid,
    input  hdr_cmd_e          fb_cmd,
    input  logic [SEQ_W-1:0]  fb_seq
);
    // DEPTH must be a power of two below 128 so that pointers wrap freely
    // and cumulative acknowledgements stay unambiguous.
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    tx_state_e         state, state_n;
    logic [IDX_W-1:0]  head;
    logic [CNT_W-1:0]  count, count_n;
    logic [CNT_W-1:0]  rp_off, rp_n;
    logic [SEQ_W-1:0]  oldest_seq;

    logic [SEQ_W-1:0]  rel_raw;
    logic              rel_ok, nak_hit;
    logic [CNT_W-1:0]  rel;
    logic              can_push, push, replay_step;
    logic [DATA_W-1:0] rd_data;

    // ---------------- feedback window decode ----------------
    always_comb begin
        rel_raw = fb_seq - oldest_seq + SEQ_W'(1);
        rel_ok  = fb_valid && (fb_cmd == CMD_ACK || fb_cmd == CMD_NAK)
                  && (rel_raw <= SEQ_W'(count));
        rel     = rel_ok ? CNT_W'(rel_raw) : '0;
        nak_hit = rel_ok && (fb_cmd == CMD_NAK);
    end

    assign can_push    = (state == ST_SEND) && (count < CNT_W'(DEPTH));
    assign push        = !raw_mode && can_push && up_valid && tx_ready;
    assign replay_step = !raw_mode && (state == ST_REPLAY) && tx_ready;
    assign count_n     = count - rel + CNT_W'(push);

    flit_replay_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (push),
        .wr_idx  (head + IDX_W'(count)),
        .wr_data (up_data),
        .rd_idx  (head + IDX_W'(rp_off)),
        .rd_data (rd_data)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_n = state;
        rp_n    = rp_off;
        unique case (state)
            ST_SEND: begin
                rp_n = '0;
                if (nak_hit && count_n != '0) begin
                    state_n = ST_REPLAY;
                end
            end
            ST_REPLAY: begin
                if (nak_hit) begin
                    rp_n = '0;
                end else if (rp_off >= rel) begin
                    rp_n = rp_off - rel + CNT_W'(replay_step);
                end else begin
                    rp_n = '0;
                end
                if (rp_n >= count_n) begin
                    state_n = ST_SEND;
                    rp_n    = '0;
                end
            end
            default: begin
                state_n = ST_SEND;
                rp_n    = '0;
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_SEND;
            head       <= '0;
            count      <= '0;
            rp_off     <= '0;
            oldest_seq <= '0;
        end else begin
            state      <= state_n;
            head       <= head + IDX_W'(rel);
            count      <= count_n;
            rp_off     <= rp_n;
            oldest_seq <= oldest_seq + SEQ_W'(rel);
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        tx_valid   = 1'b0;
        tx_hasdata = 1'b0;
        tx_data    = '0;
        tx_seq     = '0;
        tx_cmd     = CMD_NONE;
        tx_ackseq  = '0;
        up_ready   = 1'b0;
        if (raw_mode) begin
            tx_valid   = up_valid;
            tx_hasdata = up_valid;
            tx_data    = up_data;
            up_ready   = tx_ready;
        end else begin
            tx_cmd    = pend_cmd;
            tx_ackseq = pend_seq;
            up_ready  = can_push && tx_ready;
            if (state == ST_REPLAY) begin
                tx_valid   = 1'b1;
                tx_hasdata = 1'b1;
                tx_data    = rd_data;
                tx_seq     = oldest_seq + SEQ_W'(rp_off);
            end else if (up_valid && can_push) begin
                tx_valid   = 1'b1;
                tx_hasdata = 1'b1;
                tx_data    = up_data;
                tx_seq     = oldest_seq + SEQ_W'(count);
            end else begin
                tx_valid   = (pend_cmd != CMD_NONE);
            end
        end
        cmd_taken = !raw_mode && tx_valid && tx_ready;
    end

    // ---------------- assertions ----------------
    a_r3_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    a_r3_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_mode && count == CNT_W'(DEPTH)) |-> !up_ready);

    a_r4_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_valid && fb_cmd == CMD_ACK && rel_ok)
        |=> (oldest_seq == $past(fb_seq) + SEQ_W'(1)));

    a_r5_nak_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_mode && nak_hit && count_n != '0)
        |=> (raw_mode || (tx_valid && tx_hasdata && !up_ready
                          && tx_seq == $past(fb_seq) + SEQ_W'(1))));
endmodule

// File: rtl/flit_retry_rx.sv
module flit_retry_rx
    import flit_retry_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_mode,
    input  logic              rx_valid,
    input  logic              rx_hasdata,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [SEQ_W-1:0]  rx_seq,
    input  logic              rx_crc_err,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data,
    output hdr_cmd_e          pend_cmd,
    output logic [SEQ_W-1:0]  pend_seq,
    input  logic              cmd_taken
);
    rx_state_e        state, state_n;
    logic [SEQ_W-1:0] exp_seq;
    logic             ack_pend, nak_pend;
    logic             good, bad, nak_set;

    always_comb begin
        good = !raw_mode && rx_valid && rx_hasdata && !rx_crc_err
               && (rx_seq == exp_seq);
        bad  = !raw_mode && rx_valid
               && (rx_crc_err || (rx_hasdata && rx_seq != exp_seq));
    end

    // ---------------- next state ----------------
    always_comb begin
        state_n = state;
        nak_set = 1'b0;
        unique case (state)
            RX_OK: begin
                if (bad) begin
                    state_n = RX_WAIT;
                    nak_set = 1'b1;
                end
            end
            RX_WAIT: begin
                if (good) state_n = RX_OK;
            end
            default: state_n = RX_OK;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= RX_OK;
            exp_seq  <= '0;
            ack_pend <= 1'b0;
            nak_pend <= 1'b0;
            dn_valid <= 1'b0;
            dn_data  <= '0;
        end else begin
            state    <= state_n;
            if (good) exp_seq <= exp_seq + SEQ_W'(1);
            // a sent negative acknowledge also covers any pending acknowledge
            nak_pend <= nak_set || (nak_pend && !cmd_taken);
            ack_pend <= good || (ack_pend && !cmd_taken);
            dn_valid <= raw_mode ? rx_valid : good;
            dn_data  <= rx_data;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        pend_seq = exp_seq - SEQ_W'(1);
        if (nak_pend)      pend_cmd = CMD_NAK;
        else if (ack_pend) pend_cmd = CMD_ACK;
        else               pend_cmd = CMD_NONE;
    end

    // ---------------- assertions ----------------
    a_r8_bad_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_mode && rx_valid && (rx_crc_err || rx_seq != exp_seq)) |=> !dn_valid);

    a_r8_nak_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_OK && bad) |=> (pend_cmd == CMD_NAK));

    a_r7_in_order_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !$past(raw_mode)) |-> (exp_seq == $past(exp_seq) + SEQ_W'(1)));

    a_r9_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_WAIT && !nak_pend && !good) |=> !nak_pend);
endmodule

// File: rtl/flit_retry_ctrl.sv
module flit_retry_ctrl
    import flit_retry_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_mode,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_hasdata,
    output logic [DATA_W-1:0] tx_data,
    output logic [7:0]        tx_seq,
    output logic [1:0]        tx_cmd,
    output logic [7:0]        tx_ackseq,
    input  logic              rx_valid,
    input  logic              rx_hasdata,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [7:0]        rx_seq,
    input  logic [1:0]        rx_cmd,
    input  logic [7:0]        rx_ackseq,
    input  logic              rx_crc_err,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data
);
    hdr_cmd_e         pend_cmd;
    logic [SEQ_W-1:0] pend_seq;
    logic             cmd_taken;
    logic             fb_valid;
    hdr_cmd_e         fb_cmd;

    // feedback is trusted only from clean flits outside raw mode
    assign fb_valid = !raw_mode && rx_valid && !rx_crc_err;
    assign fb_cmd   = hdr_cmd_e'(rx_cmd);

    flit_replay_tx #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_mode   (raw_mode),
        .up_valid   (up_valid),
        .up_ready   (up_ready),
        .up_data    (up_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_hasdata (tx_hasdata),
        .tx_data    (tx_data),
        .tx_seq     (tx_seq),
        .tx_cmd     (tx_cmd),
        .tx_ackseq  (tx_ackseq),
        .pend_cmd   (pend_cmd),
        .pend_seq   (pend_seq),
        .cmd_taken  (cmd_taken),
        .fb_valid   (fb_valid),
        .fb_cmd     (fb_cmd),
        .fb_seq     (rx_ackseq)
    );

    flit_retry_rx #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_mode   (raw_mode),
        .rx_valid   (rx_valid),
        .rx_hasdata (rx_hasdata),
        .rx_data    (rx_data),
        .rx_seq     (rx_seq),
        .rx_crc_err (rx_crc_err),
        .dn_valid   (dn_valid),
        .dn_data    (dn_data),
        .pend_cmd   (pend_cmd),
        .pend_seq   (pend_seq),
        .cmd_taken  (cmd_taken)
    );

    a_r11_raw_plain: assert property (@(posedge clk) disable iff (!rst_n)
        raw_mode |-> (tx_cmd == 2'b00 && tx_valid == up_valid && up_ready == tx_ready));
endmodule

// File: tb/flit_retry_ctrl_bench.sv
module flit_retry_ctrl_bench;
    localparam int DW    = 32;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          raw_mode = 1'b0;
    logic          up_valid = 1'b0;
    logic          up_ready;
    logic [DW-1:0] up_data = '0;
    logic          tx_valid;
    logic          tx_ready = 1'b1;
    logic          tx_hasdata;
    logic [DW-1:0] tx_data;
    logic [7:0]    tx_seq;
    logic [1:0]    tx_cmd;
    logic [7:0]    tx_ackseq;
    logic          rx_valid = 1'b0;
    logic          rx_hasdata = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic [7:0]    rx_seq = '0;
    logic [1:0]    rx_cmd = 2'b00;
    logic [7:0]    rx_ackseq = '0;
    logic          rx_crc_err = 1'b0;
    logic          dn_valid;
    logic [DW-1:0] dn_data;

    always #5 clk = ~clk;

    flit_retry_ctrl #(.DATA_W(DW), .DEPTH(DEPTH)) u_flit_retry_ctrl (.*);

    int total = 0;
    int bad   = 0;
    logic [39:0] expq [$];
    logic [39:0] outq [$];
    logic [DW-1:0] rxq [$];
    logic [7:0] nseq = 8'd0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // tx scoreboard monitor
    always @(negedge clk) begin : tx_mon
        logic [39:0] e;
        if (rst_n && !raw_mode && tx_valid && tx_ready && tx_hasdata) begin
            if (expq.size() == 0) begin
                total++; bad++;
                $display("FAIL R5 unexpected data flit: actual seq=%0h expected=none", tx_seq);
            end else begin
                e = expq.pop_front();
                chk("R2/R5 tx flit {seq,data}", {24'd0, tx_seq, tx_data}, {24'd0, e});
            end
        end
    end

    // rx scoreboard monitor
    always @(negedge clk) begin : rx_mon
        logic [DW-1:0] d;
        if (rst_n && dn_valid) begin
            if (rxq.size() == 0) begin
                total++; bad++;
                $display("FAIL R8 unexpected delivery: actual=%0h expected=none", dn_data);
            end else begin
                d = rxq.pop_front();
                chk("R7/R11 delivered data", {32'd0, dn_data}, {32'd0, d});
            end
        end
    end

    task automatic model_release(input logic [7:0] n);
        logic [7:0] oldest, rel;
        oldest = (outq.size() != 0) ? outq[0][39:32] : nseq;
        rel = n - oldest + 8'd1;
        if (int'(rel) <= outq.size())
            repeat (int'(rel)) void'(outq.pop_front());
    endtask

    task automatic send_flit(input logic [DW-1:0] d);
        @(posedge clk); #1;
        up_valid = 1'b1; up_data = d;
        #1;
        while (!up_ready) begin @(posedge clk); #2; end
        expq.push_back({nseq, d});
        outq.push_back({nseq, d});
        nseq = nseq + 8'd1;
        @(posedge clk); #1;
        up_valid = 1'b0;
    endtask

    task automatic fb(input logic [1:0] cmd, input logic [7:0] n, input logic crc);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_hasdata = 1'b0; rx_cmd = cmd; rx_ackseq = n; rx_crc_err = crc;
        if (!crc && cmd == 2'b01) model_release(n);
        if (!crc && cmd == 2'b10) begin
            model_release(n);
            foreach (outq[i]) expq.push_back(outq[i]);
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_cmd = 2'b00; rx_crc_err = 1'b0;
    endtask

    task automatic rxf(input logic [7:0] s, input logic [DW-1:0] d, input logic crc, input logic deliver);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_hasdata = 1'b1; rx_seq = s; rx_data = d;
        rx_crc_err = crc; rx_cmd = 2'b00;
        if (deliver) rxq.push_back(d);
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_hasdata = 1'b0; rx_crc_err = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 40 && expq.size() != 0; i++) @(posedge clk);
        @(negedge clk);
        chk(req, expq.size(), 0);
    endtask

    initial begin : watchdog
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx_valid after reset", tx_valid, 0);
        chk("R1 dn_valid after reset", dn_valid, 0);
        chk("R1 up_ready after reset", up_ready, 1);

        // R2: consecutive numbering
        for (int i = 0; i < 3; i++) send_flit(32'h1000_0000 + i);
        // R4: cumulative ack of seq 1
        fb(2'b01, 8'd1, 1'b0);
        // R3: fill to DEPTH (seq 2..9 held)
        for (int i = 0; i < 7; i++) send_flit(32'h2000_0000 + i);
        @(posedge clk); #1 up_valid = 1'b1; up_data = 32'hDEAD_0000; #1;
        chk("R3 up_ready when full", up_ready, 0);
        @(negedge clk); up_valid = 1'b0;

        // R5: nak 4 -> release 2..4, resend 5..9
        fb(2'b10, 8'd4, 1'b0);
        @(negedge clk);
        chk("R5 up_ready during replay", up_ready, 0);
        drain("R5 replay complete");

        // R4: stale ack ignored, then nak with zero release resends 5..9
        fb(2'b01, 8'd2, 1'b0);
        fb(2'b10, 8'd4, 1'b0);
        drain("R4 stale ack ignored");
        fb(2'b01, 8'd9, 1'b0);

        // R2: long stream across the wrap
        for (int i = 0; i < 244; i++) begin
            send_flit(32'hA000_0000 + i);
            if (i % 4 == 3) fb(2'b01, nseq - 8'd1, 1'b0);
        end
        chk("R2 seq reached 254", nseq, 8'd254);
        for (int i = 0; i < 3; i++) send_flit(32'hB000_0000 + i);
        fb(2'b10, 8'd254, 1'b0);
        drain("R5 replay across wrap");
        fb(2'b01, 8'd0, 1'b0);

        // receive side
        rxf(8'd0, 32'hC000_0000, 1'b0, 1'b1);
        @(negedge clk);
        chk("R7 ack cmd", tx_cmd, 2'b01);
        chk("R7 ack seq", tx_ackseq, 8'd0);
        chk("R10 command-only flit valid", tx_valid, 1);
        chk("R10 command-only flit no data", tx_hasdata, 0);
        rxf(8'd1, 32'hC000_0001, 1'b0, 1'b1);
        @(negedge clk);
        chk("R7 ack seq 1", {tx_cmd, tx_ackseq}, {2'b01, 8'd1});
        rxf(8'd2, 32'hC000_0002, 1'b1, 1'b0);
        @(negedge clk);
        chk("R8 nak on crc error", {tx_cmd, tx_ackseq}, {2'b10, 8'd1});
        rxf(8'd3, 32'hC000_0003, 1'b0, 1'b0);
        @(negedge clk);
        chk("R9 silent drop in wait", tx_cmd, 2'b00);
        rxf(8'd2, 32'hC000_0012, 1'b0, 1'b1);
        @(negedge clk);
        chk("R9 recovery ack", {tx_cmd, tx_ackseq}, {2'b01, 8'd2});
        rxf(8'd5, 32'hC000_0005, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 nak on wrong seq", {tx_cmd, tx_ackseq}, {2'b10, 8'd2});
        rxf(8'd3, 32'hC000_0013, 1'b0, 1'b1);
        @(negedge clk);
        chk("R9 ack after wait", {tx_cmd, tx_ackseq}, {2'b01, 8'd3});

        // R6: reserved command and crc-flagged nak have no effect
        send_flit(32'hD000_0001);
        send_flit(32'hD000_0002);
        fb(2'b11, 8'd2, 1'b0);
        fb(2'b10, 8'd0, 1'b1);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R6 no replay after ignored commands", expq.size(), 0);
        fb(2'b10, 8'd0, 1'b0);
        drain("R6 both flits still held");
        fb(2'b01, 8'd2, 1'b0);
        rxf(8'd4, 32'hC000_0004, 1'b0, 1'b1);
        repeat (2) @(posedge clk);

        // R11: raw mode
        @(posedge clk); #1;
        raw_mode = 1'b1; up_valid = 1'b1; up_data = 32'hCAFE_F00D; #1;
        chk("R11 raw tx_valid", tx_valid, 1);
        chk("R11 raw tx_data", tx_data, 32'hCAFE_F00D);
        chk("R11 raw tx_cmd", tx_cmd, 2'b00);
        tx_ready = 1'b0; #1;
        chk("R11 raw up_ready follows tx_ready", up_ready, 0);
        tx_ready = 1'b1; up_valid = 1'b0;
        rx_valid = 1'b1; rx_hasdata = 1'b1; rx_crc_err = 1'b1; rx_data = 32'h0000_1234;
        rxq.push_back(32'h0000_1234);
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_crc_err = 1'b0;
        @(posedge clk); #1;
        raw_mode = 1'b0; #1;
        chk("R11 no command raised by raw traffic", tx_cmd, 2'b00);
        send_flit(32'hE000_0003);
        drain("R11 seq resumes after raw");

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 all deliveries seen", rxq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule